// File: doc/BRIEF.md
# Carry-Aware Barrel Shifter

This block is the shift unit of a 16-bit multi-cycle datapath. It takes an operand and a shift count, and shifts the operand by 0 to 15 places in one of eight ways. It also takes the current carry flag. It returns the shifted value, a new carry, and zero, negative and overflow indications that the status logic can latch.

The eight ways are logical left and right, arithmetic left and right, plain rotate left and right, and rotate left and right through the carry flag. Each one has its own rule for the bit that enters the vacated end. The count arrives as a full 16-bit source operand, and only its low four bits are used.

Internally the shift runs through a chain of power-of-two stages. Each stage either passes its word on or moves it by its own step. The results are captured in an output register, so every result appears one clock edge after its inputs are presented.

Top module: `carry_barrel_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is driven to 0 after that edge.
- R2: Only bits [3:0] of `amount_i` set the shift count. Bits [15:4] have no effect on any output.
- R3: When the shift count is 0, `result_o` equals the operand, `carry_o` equals `carry_i` and `ovf_o` is 0, whatever the mode.
- R4: Modes 3'b000 (logical left) and 3'b001 (logical right) fill vacated positions with 0. For a count s > 0, `carry_o` is the last bit shifted out: operand bit 16-s for left, operand bit s-1 for right.
- R5: Mode 3'b010 (arithmetic left) fills vacated positions with 0. For a count s > 0, `carry_o` is operand bit 16-s.
- R6: Mode 3'b011 (arithmetic right) fills vacated positions with operand bit 15. For a count s > 0, `carry_o` is operand bit s-1.
- R7: Modes 3'b100 (rotate left) and 3'b101 (rotate right) feed each bit that leaves one end into the other end. For a count s > 0, `carry_o` is the last bit moved around: `result_o[0]` for left, `result_o[15]` for right.
- R8: Modes 3'b110 and 3'b111 rotate through the carry flag, treating the data as 17 bits. In mode 3'b110, each one-place step sets the new carry to bit 15 and moves the old carry into bit 0. In mode 3'b111, each step sets the new carry to bit 0 and moves the old carry into bit 15.
- R9: `ovf_o` is 1 only in mode 3'b010, and only when at least one of operand bits 14 down to 15-s differs from operand bit 15. In every other case it is 0.
- R10: `zero_o` is 1 exactly when `result_o` is all zeros, and `neg_o` equals `result_o[15]`.
- R11: All outputs change only at a rising edge, and show the result for the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_i | input | 16 | Operand to be shifted |
| amount_i | input | 16 | Shift count operand (bits [3:0] used) |
| mode_i | input | 3 | Shift kind, encoded as in R4 to R8 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 16 | Shifted value |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Sign bit of the result |
| ovf_o | output | 1 | Sign changed during an arithmetic left shift |

## Verification
Every output is due exactly one rising edge after its inputs are presented. The bench drives inputs on a falling edge and compares all five outputs on the next falling edge, after the capturing rising edge has passed. For the one-edge latency, one directed case also samples the outputs a quarter period after new inputs are driven, before the next rising edge, and expects the previous result to still be shown. Expected values come from a bench model that steps the operand one place at a time. The stimulus mixes random cases with directed ones: count 0, count 15, counts with high bits set, and sign-change cases.

// File: rtl/bsc_pkg.sv
// Package: shared encodings for the carry-aware barrel shifter.
// Assumes nothing beyond IEEE 1800-2017; the mode codes are visible at the
// top-level port and must not be reordered.
package bsc_pkg;

    // Shift kind as presented on mode_i
    typedef enum logic [2:0] {
        SM_LSL = 3'b000,   // logical left, zero fill
        SM_LSR = 3'b001,   // logical right, zero fill
        SM_ASL = 3'b010,   // arithmetic left, zero fill, overflow tracked
        SM_ASR = 3'b011,   // arithmetic right, sign fill
        SM_ROL = 3'b100,   // rotate left
        SM_ROR = 3'b101,   // rotate right
        SM_RCL = 3'b110,   // rotate left through carry
        SM_RCR = 3'b111    // rotate right through carry
    } shift_mode_e;

endpackage

// File: rtl/bsc_stage.sv
// Module: bsc_stage
// One power-of-two step of the shifter chain. When en_i is set the word is
// moved by STEP places using the fill rule of the selected mode, and cy_o
// takes the last bit that left the word. Through-carry modes rotate the
// 17-bit value {carry, data}. Assumes 0 < STEP < W. Purely combinational.
module bsc_stage
    import bsc_pkg::*;
#(
    parameter int W    = 16,
    parameter int STEP = 1
) (
    input  logic [W-1:0]  d_i,
    input  logic          cy_i,
    input  logic          en_i,
    input  shift_mode_e   mode_i,
    output logic [W-1:0]  d_o,
    output logic          cy_o
);
    localparam int EW     = W + 1;
    localparam int LO_OUT = STEP - 1;
    localparam int HI_OUT = W - STEP;

    logic [EW-1:0] ext;
    logic [EW-1:0] rot;

    // Select the moved word and outgoing carry for the active mode
    always_comb begin
        ext  = {cy_i, d_i};
        rot  = ext;
        d_o  = d_i;
        cy_o = cy_i;
        if (en_i) begin
            case (mode_i)
                SM_LSL, SM_ASL: begin
                    d_o  = d_i << STEP;
                    cy_o = d_i[HI_OUT];
                end
                SM_LSR: begin
                    d_o  = d_i >> STEP;
                    cy_o = d_i[LO_OUT];
                end
                SM_ASR: begin
                    d_o  = $unsigned($signed(d_i) >>> STEP);
                    cy_o = d_i[LO_OUT];
                end
                SM_ROL: begin
                    d_o  = (d_i << STEP) | (d_i >> (W - STEP));
                    cy_o = d_i[HI_OUT];
                end
                SM_ROR: begin
                    d_o  = (d_i >> STEP) | (d_i << (W - STEP));
                    cy_o = d_i[LO_OUT];
                end
                SM_RCL: begin
                    rot  = (ext << STEP) | (ext >> (EW - STEP));
                    d_o  = rot[W-1:0];
                    cy_o = rot[W];
                end
                SM_RCR: begin
                    rot  = (ext >> STEP) | (ext << (EW - STEP));
                    d_o  = rot[W-1:0];
                    cy_o = rot[W];
                end
                default: begin
                    d_o  = d_i;
                    cy_o = cy_i;
                end
            endcase
        end
    end

endmodule

// File: rtl/bsc_flags.sv
// Module: bsc_flags
// Derives zero, negative and overflow from the unshifted operand, the count
// and the shifted result. Overflow is worked out directly from the operand:
// an arithmetic left shift by s changes the sign at some step exactly when
// one of bits W-2 .. W-1-s differs from bit W-1. Combinational.
module bsc_flags
    import bsc_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = 4
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  shift_mode_e      mode_i,
    input  logic [W-1:0]     res_i,
    output logic             zero_o,
    output logic             neg_o,
    output logic             ovf_o
);
    logic v_any;

    // Scan the bits that pass through the sign position
    always_comb begin
        v_any = 1'b0;
        for (int i = 1; i < W; i++) begin
            if (i <= int'(amt_i) && opnd_i[W-1-i] != opnd_i[W-1])
                v_any = 1'b1;
        end
    end

    // Gate overflow by mode and form result flags
    always_comb begin
        ovf_o  = (mode_i == SM_ASL) && v_any;
        zero_o = (res_i == '0);
        neg_o  = res_i[W-1];
    end

endmodule

// File: rtl/carry_barrel_shifter.sv
// Module: carry_barrel_shifter
// Eight-mode shifter with carry. The count is the low log2(W) bits of a
// full-width amount operand. A chain of log2(W) stages with steps 1,2,4,..
// forms the result; outputs are registered, one edge of latency.
// Assumes W is a power of two and greater than 2. Synchronous active-low reset.
module carry_barrel_shifter
    import bsc_pkg::*;
#(
    parameter int W     = 16,
    parameter int AMT_W = $clog2(W),
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     opnd_i,
    input  logic [CNT_W-1:0] amount_i,
    input  logic [2:0]       mode_i,
    input  logic             carry_i,
    output logic [W-1:0]     result_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             ovf_o
);
    localparam int NSTG = AMT_W;

    shift_mode_e      mode;
    logic [AMT_W-1:0] amt;
    logic [W-1:0]     d_chain [0:NSTG];
    logic             c_chain [0:NSTG];
    logic             z_nxt, n_nxt, v_nxt;

    // Decode mode and keep only the meaningful count bits
    always_comb begin
        mode       = shift_mode_e'(mode_i);
        amt        = amount_i[AMT_W-1:0];
        d_chain[0] = opnd_i;
        c_chain[0] = carry_i;
    end

    genvar k;
    generate
        for (k = 0; k < NSTG; k++) begin : g_stage
            bsc_stage #(
                .W    (W),
                .STEP (1 << k)
            ) u_stage (
                .d_i    (d_chain[k]),
                .cy_i   (c_chain[k]),
                .en_i   (amt[k]),
                .mode_i (mode),
                .d_o    (d_chain[k+1]),
                .cy_o   (c_chain[k+1])
            );
        end
    endgenerate

    bsc_flags #(
        .W     (W),
        .AMT_W (AMT_W)
    ) u_flags (
        .opnd_i (opnd_i),
        .amt_i  (amt),
        .mode_i (mode),
        .res_i  (d_chain[NSTG]),
        .zero_o (z_nxt),
        .neg_o  (n_nxt),
        .ovf_o  (v_nxt)
    );

    // Capture result and flags, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
            zero_o   <= 1'b0;
            neg_o    <= 1'b0;
            ovf_o    <= 1'b0;
        end else begin
            result_o <= d_chain[NSTG];
            carry_o  <= c_chain[NSTG];
            zero_o   <= z_nxt;
            neg_o    <= n_nxt;
            ovf_o    <= v_nxt;
        end
    end

    // R1: reset clears every output
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !carry_o && !zero_o && !neg_o && !ovf_o));

    // R3: a zero count passes operand and carry through
    assert_zero_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (amount_i[AMT_W-1:0] == '0) |=>
        (result_o == $past(opnd_i) && carry_o == $past(carry_i) && !ovf_o));

    // R7: a plain rotate keeps the population count
    assert_rotate_popcount_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_ROL || mode_i == SM_ROR) |=>
        ($countones(result_o) == $countones($past(opnd_i))));

    // R8: a through-carry rotate keeps the population count of {carry, data}
    assert_carry_rotate_popcount_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_RCL || mode_i == SM_RCR) |=>
        ($countones({carry_o, result_o}) == $countones({$past(carry_i), $past(opnd_i)})));

    // R6: arithmetic right keeps the sign
    assert_asr_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_ASR) |=> (result_o[W-1] == $past(opnd_i[W-1])));

    // R9: overflow only for arithmetic left
    assert_ovf_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != SM_ASL) |=> !ovf_o);

    // R4: a left logical shift by a nonzero count clears bit 0
    assert_lsl_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SM_LSL && amount_i[AMT_W-1:0] != '0) |=> !result_o[0]);

endmodule

// File: tb/carry_barrel_shifter_bench.sv
module carry_barrel_shifter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_i = 16'hA5C3;
    logic [15:0] amount_i = 16'h0005;
    logic [2:0]  mode_i = 3'b011;
    logic        carry_i = 1'b1;
    logic [15:0] result_o;
    logic        carry_o, zero_o, neg_o, ovf_o;

    int total = 0;
    int bad = 0;
    logic [17:0] exp_v;
    string       exp_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    carry_barrel_shifter u_carry_barrel_shifter (
        .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .amount_i(amount_i),
        .mode_i(mode_i), .carry_i(carry_i), .result_o(result_o),
        .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
    );

    // Bit-at-a-time model: returns {ovf, carry, result}
    function automatic logic [17:0] ref_shift(input logic [15:0] op, input logic [15:0] amt,
                                              input logic [2:0] md, input logic cin);
        logic [15:0] r; logic c, v, t; int s;
        r = op; c = cin; v = 1'b0; s = int'(amt[3:0]);
        for (int i = 0; i < s; i++) begin
            case (md)
                3'd0: begin c = r[15]; r = {r[14:0], 1'b0}; end
                3'd1: begin c = r[0];  r = {1'b0, r[15:1]}; end
                3'd2: begin if (r[15] != r[14]) v = 1'b1; c = r[15]; r = {r[14:0], 1'b0}; end
                3'd3: begin c = r[0];  r = {r[15], r[15:1]}; end
                3'd4: begin c = r[15]; r = {r[14:0], r[15]}; end
                3'd5: begin c = r[0];  r = {r[0], r[15:1]}; end
                3'd6: begin t = r[15]; r = {r[14:0], c}; c = t; end
                default: begin t = r[0]; r = {c, r[15:1]}; c = t; end
            endcase
        end
        return {v, c, r};
    endfunction

    function automatic string req_of(input logic [15:0] amt, input logic [2:0] md);
        if (amt[15:4] != 0) return "R2";
        if (amt[3:0] == 0) return "R3";
        case (md)
            3'd0, 3'd1: return "R4";
            3'd2:       return "R5";
            3'd3:       return "R6";
            3'd4, 3'd5: return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge and remember the expectation
    task automatic drive(input logic [15:0] op, input logic [15:0] amt,
                         input logic [2:0] md, input logic c);
        opnd_i = op; amount_i = amt; mode_i = md; carry_i = c;
        exp_v = ref_shift(op, amt, md, c);
        exp_tag = req_of(amt, md);
    endtask

    task automatic check_all();
        chk(result_o == exp_v[15:0], exp_tag, "result", result_o, exp_v[15:0]);
        chk(carry_o == exp_v[16], exp_tag, "carry", {15'd0, carry_o}, {15'd0, exp_v[16]});
        chk(ovf_o == exp_v[17], "R9", "ovf", {15'd0, ovf_o}, {15'd0, exp_v[17]});
        chk(zero_o == (exp_v[15:0] == 0), "R10", "zero", {15'd0, zero_o}, {15'd0, exp_v[15:0] == 0});
        chk(neg_o == exp_v[15], "R10", "neg", {15'd0, neg_o}, {15'd0, exp_v[15]});
    endtask

    task automatic apply(input logic [15:0] op, input logic [15:0] amt,
                         input logic [2:0] md, input logic c);
        drive(op, amt, md, c);
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [15:0] prev;
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd771903);
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        chk(result_o == 0 && !carry_o && !zero_o && !neg_o && !ovf_o, "R1", "reset outputs",
            result_o, 16'h0000);
        rst_n = 1'b1;

        // Directed corners
        for (int m = 0; m < 8; m++) begin
            apply(16'h8001, 16'd0, 3'(m), 1'b1);          // R3 count zero
            apply(16'hB4C9, 16'd1, 3'(m), 1'b0);
            apply(16'hB4C9, 16'd15, 3'(m), 1'b1);
            apply(16'h6D2E, 16'hFFF3, 3'(m), 1'b1);       // R2 high bits ignored
            apply(16'h6D2E, 16'h0010, 3'(m), 1'b0);       // R2 count reduces to 0
        end
        apply(16'h4000, 16'd1, 3'd2, 1'b0);   // R9 sign flips on first step
        apply(16'hC000, 16'd1, 3'd2, 1'b0);   // R9 no flip
        apply(16'hC000, 16'd2, 3'd2, 1'b0);   // R9 flip at step two
        apply(16'hFFFF, 16'd15, 3'd2, 1'b0);  // R9 all ones, no flip
        apply(16'h8000, 16'd15, 3'd3, 1'b0);  // R6 sign fill to all ones
        apply(16'h0001, 16'd1, 3'd1, 1'b0);   // R10 zero result, carry out 1
        apply(16'h0000, 16'd7, 3'd7, 1'b1);   // R8 carry enters bit 9
        apply(16'h0000, 16'd15, 3'd6, 1'b1);  // R8 carry enters bit 14

        // R11: output holds old result until the next rising edge
        apply(16'h1234, 16'd4, 3'd4, 1'b0);
        prev = exp_v[15:0];
        drive(16'hFEDC, 16'd3, 3'd0, 1'b0);
        #(CLK_PERIOD/4);
        chk(result_o == prev, "R11", "held before edge", result_o, prev);
        @(negedge clk);
        check_all();

        // Random stimulus
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 16);
            apply(16'($urandom), a, 3'($urandom), 1'($urandom));
        end

        // R1: reset during operation
        drive(16'hFFFF, 16'd0, 3'd0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(result_o == 0 && !carry_o && !zero_o && !neg_o && !ovf_o, "R1", "mid-run reset",
            result_o, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule